// File: doc/BRIEF.md
# Power-Up Permit Time-Slot Sequencer

This block releases four downstream converter-enable lines in a software-chosen order once the main supply path has finished charging the load. It watches two comparator flags. One says the pass device's gate is fully enhanced, and that fact is latched. The other says the voltage across the pass device has fallen below its threshold. A current-regulation mode flag makes the block ignore the second flag. When both conditions hold, the block is qualified to start.

Once qualified, the block walks through four time slots in ascending order, spaced by a programmable number of clock cycles. Each output is tied to one slot through a 2-bit field. It switches on when its slot is reached and then stays on. Several outputs may share a slot, and a slot may hold no outputs. Each output is an open-drain pull-low enable with its own polarity bit. Dropping the master enable puts everything back to the idle, inactive state in the same cycle.

Top module: `pup_permit_seq`

## Requirements
- R1: While reset is held or `enable` is low, every bit of `pull_low` equals the matching bit of `pol` (inactive) and `seq_done` is 0.
- R2: Sequencing starts only when the latched gate condition is true and `drain_low` is 1 (or `creg_mode` is 1). With both flags high from a given cycle, slot 0 is reached on the second rising edge. The first edge latches the gate flag.
- R3: The gate condition is latched: a single-cycle pulse on `gate_full` satisfies it for the rest of the enabled period.
- R4: While `creg_mode` is 1, `drain_low` has no effect and the start depends only on the latched gate condition.
- R5: Slot k (k = 0..3) is reached k*G cycles after slot 0, where G = `slot_gap`, except that a value of 0 gives G = 1. Once started, the comparator flags no longer affect the sequence.
- R6: Output i takes its slot number from `slot_map[2i+1:2i]`. It becomes active on the cycle its slot is reached and stays active while `enable` remains high.
- R7: Any number of outputs may share a slot. An empty slot still takes its full interval of G cycles.
- R8: `pull_low[i]` equals (output i active) XOR `pol[i]`.
- R9: `seq_done` rises 4*G cycles after slot 0 is reached, which is one interval after slot 3 is entered. When it is 1, all outputs are active.
- R10: Removing `enable` makes all outputs inactive in the same cycle and clears the latched gate condition. A later re-enable needs a fresh `gate_full` before it starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Master enable; low returns to idle |
| gate_full | input | 1 | Gate-enhanced comparator flag |
| drain_low | input | 1 | Drain voltage below threshold flag |
| creg_mode | input | 1 | Current-regulation mode; masks `drain_low` |
| slot_map | input | 8 | 2-bit slot number per output, output i at bits [2i+1:2i] |
| pol | input | 4 | Per-output polarity bit |
| slot_gap | input | 16 | Cycles between successive slots (0 acts as 1) |
| pull_low | output | 4 | Open-drain pull-low enables |
| seq_done | output | 1 | All slots entered and last interval elapsed |

## Verification
The checker asserts on every cycle the following properties. Outputs sit at their inactive level whenever `enable` is low. The latched gate flag never drops while enabled. Active outputs never turn off while the configuration is stable. The slot index advances by at most one per cycle. A start only follows a true qualifier. `seq_done` implies all outputs are active. Only the bench's scenarios can show the exact slot timing for a given interval, the zero-interval case, empty and shared slots, the masking of the drain flag, and the refusal to restart without a fresh gate pulse. It does so by comparing every cycle against a reference model built from the requirements.

// File: rtl/pup_seq_pkg.sv
// Shared types for the power-up permit sequencer.
// Assumes: a small sequencer state, encoded in 2 bits.
package pup_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pup_start_qual.sv
// Start qualifier: latches the gate-enhanced flag and combines it with the
// drain check, which current-regulation mode masks.
// Assumes: the flags are synchronous to clk; enable low clears the latch.
module pup_start_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic gate_full,
    input  logic drain_low,
    input  logic creg_mode,
    output logic gate_seen,
    output logic start_ok
);
    logic drain_ok;

    // Latch the gate condition once it is seen; clear on reset or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            gate_seen <= 1'b0;
        end else if (gate_full) begin
            gate_seen <= 1'b1;
        end
    end

    // Drain check counts as satisfied while regulation mode is on.
    always_comb begin
        drain_ok = drain_low | creg_mode;
        start_ok = gate_seen & drain_ok;
    end
endmodule

// File: rtl/pup_slot_sched.sv
// Slot scheduler: on a qualified start, enters slot 0, then advances one slot
// every max(slot_gap,1) cycles, and reports done one interval after the last.
// Assumes: slot_gap is held steady during a sequence.
module pup_slot_sched
    import pup_seq_pkg::*;
#(
    parameter int N_SLOT = 4,
    parameter int GAP_W  = 16,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_ok,
    input  logic [GAP_W-1:0]  slot_gap,
    output logic              busy,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [N_SLOT-1:0] reached,
    output logic              done
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOT - 1);

    seq_state_t       state_q;
    logic [GAP_W-1:0] cnt_q;
    logic [GAP_W-1:0] gap_last;
    logic             gap_end;

    // Last count value of an interval; a zero gap behaves as one cycle.
    always_comb begin
        gap_last = (slot_gap == '0) ? '0 : slot_gap - 1'b1;
        gap_end  = (cnt_q == gap_last);
    end

    // Sequencer state, slot index and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q  <= SEQ_IDLE;
            slot_idx <= '0;
            cnt_q    <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_ok) begin
                        state_q  <= SEQ_RUN;
                        slot_idx <= '0;
                        cnt_q    <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (gap_end) begin
                        cnt_q <= '0;
                        if (slot_idx == LAST_SLOT) begin
                            state_q <= SEQ_DONE;
                        end else begin
                            slot_idx <= slot_idx + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_DONE: begin
                    state_q <= SEQ_DONE;
                end
                default: begin
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    // Thermometer of slots reached so far.
    for (genvar s = 0; s < N_SLOT; s++) begin : g_reach
        always_comb begin
            reached[s] = (state_q == SEQ_DONE) ||
                         ((state_q == SEQ_RUN) && (slot_idx >= SLOT_W'(s)));
        end
    end

    // Status decode.
    always_comb begin
        busy = (state_q != SEQ_IDLE);
        done = (state_q == SEQ_DONE);
    end
endmodule

// File: rtl/pup_permit_drive.sv
// Output stage: maps each permit to its slot, gates with enable and reset,
// and applies the per-output polarity to form the pull-low enable.
// Assumes: slot_map packs one SLOT_W field per output, output 0 lowest.
module pup_permit_drive #(
    parameter int N_OUT  = 4,
    parameter int N_SLOT = 4,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic [N_SLOT-1:0]       reached,
    input  logic [N_OUT*SLOT_W-1:0] slot_map,
    input  logic [N_OUT-1:0]        pol,
    output logic [N_OUT-1:0]        pull_low
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        logic [SLOT_W-1:0] sel;
        logic              on;
        // Select this output's slot, qualify, apply polarity.
        always_comb begin
            sel         = slot_map[i*SLOT_W +: SLOT_W];
            on          = rst_n & enable & reached[sel];
            pull_low[i] = on ^ pol[i];
        end
    end
endmodule

// File: rtl/pup_permit_seq.sv
// Top: power-up permit time-slot sequencer. Qualifies the start from the
// comparator flags, schedules four slots and drives four permit outputs.
// Assumes: synchronous active-low reset; configuration stable during a run.
module pup_permit_seq #(
    parameter int N_OUT  = 4,
    parameter int N_SLOT = 4,
    parameter int GAP_W  = 16,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    gate_full,
    input  logic                    drain_low,
    input  logic                    creg_mode,
    input  logic [N_OUT*SLOT_W-1:0] slot_map,
    input  logic [N_OUT-1:0]        pol,
    input  logic [GAP_W-1:0]        slot_gap,
    output logic [N_OUT-1:0]        pull_low,
    output logic                    seq_done
);
    logic              gate_seen;
    logic              start_ok;
    logic              busy;
    logic [SLOT_W-1:0] slot_idx;
    logic [N_SLOT-1:0] reached;
    logic              sched_done;

    pup_start_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .gate_full (gate_full),
        .drain_low (drain_low),
        .creg_mode (creg_mode),
        .gate_seen (gate_seen),
        .start_ok  (start_ok)
    );

    pup_slot_sched #(.N_SLOT(N_SLOT), .GAP_W(GAP_W)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .start_ok (start_ok),
        .slot_gap (slot_gap),
        .busy     (busy),
        .slot_idx (slot_idx),
        .reached  (reached),
        .done     (sched_done)
    );

    pup_permit_drive #(.N_OUT(N_OUT), .N_SLOT(N_SLOT)) u_drive (
        .rst_n    (rst_n),
        .enable   (enable),
        .reached  (reached),
        .slot_map (slot_map),
        .pol      (pol),
        .pull_low (pull_low)
    );

    // Done status, dropped immediately with enable or reset.
    always_comb begin
        seq_done = sched_done & enable & rst_n;
    end
endmodule

// File: rtl/pup_permit_seq_chk.sv
// Checker for the permit sequencer, bound to the top module.
// Assumes: it sees the top's ports and internal qualifier/scheduler nets.
module pup_permit_seq_chk #(
    parameter int N_OUT  = 4,
    parameter int N_SLOT = 4,
    parameter int SLOT_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    enable,
    input logic                    drain_low,
    input logic                    creg_mode,
    input logic [N_OUT*SLOT_W-1:0] slot_map,
    input logic [N_OUT-1:0]        pol,
    input logic [N_OUT-1:0]        pull_low,
    input logic                    seq_done,
    input logic                    gate_seen,
    input logic                    busy,
    input logic [SLOT_W-1:0]       slot_idx
);
    // R1
    idle_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (pull_low == pol) && !seq_done);

    // R10
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !gate_seen && !busy && !seq_done);

    // R3
    gate_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $past(gate_seen)) |-> gate_seen);

    // R2
    start_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(gate_seen && (drain_low || creg_mode)));

    // R5
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            (slot_idx == $past(slot_idx)) || (slot_idx == $past(slot_idx) + 1'b1));

    // R6
    stay_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $stable(pol) && $stable(slot_map)) |->
            ((($past(pull_low) ^ pol) & ~(pull_low ^ pol)) == '0));

    // R9
    done_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> ((pull_low ^ pol) == {N_OUT{1'b1}}));
endmodule

bind pup_permit_seq pup_permit_seq_chk #(
    .N_OUT(N_OUT), .N_SLOT(N_SLOT), .SLOT_W(SLOT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .drain_low (drain_low),
    .creg_mode (creg_mode),
    .slot_map  (slot_map),
    .pol       (pol),
    .pull_low  (pull_low),
    .seq_done  (seq_done),
    .gate_seen (gate_seen),
    .busy      (busy),
    .slot_idx  (slot_idx)
);

// File: tb/pup_permit_seq_tb_top.sv
// Bench: per-cycle comparison against a requirement-level reference model,
// driven by directed cases and seeded random cases.
module pup_permit_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        gate_f = 1'b0;
    logic        drain_l = 1'b0;
    logic        creg = 1'b0;
    logic [7:0]  smap = '0;
    logic [3:0]  pol = '0;
    logic [15:0] gap = 16'd1;
    logic [3:0]  pull_low;
    logic        seq_done;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic m_gate = 1'b0;
    logic m_run  = 1'b0;
    int   m_el   = 0;

    always #4 clk = ~clk;

    pup_permit_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (en),
        .gate_full (gate_f),
        .drain_low (drain_l),
        .creg_mode (creg),
        .slot_map  (smap),
        .pol       (pol),
        .slot_gap  (gap),
        .pull_low  (pull_low),
        .seq_done  (seq_done)
    );

    // Reference model of qualifier and elapsed time since slot 0.
    always @(posedge clk) begin
        if (!rst_n || !en) begin
            m_gate <= 1'b0;
            m_run  <= 1'b0;
            m_el   <= 0;
        end else begin
            if (gate_f) m_gate <= 1'b1;
            if (m_run) m_el <= m_el + 1;
            else if (m_gate && (drain_l || creg)) begin
                m_run <= 1'b1;
                m_el  <= 0;
            end
        end
    end

    function automatic int eff_gap(input logic [15:0] g);
        return (g == 0) ? 1 : int'(g);
    endfunction

    function automatic logic [3:0] exp_pull(input logic run, input int el,
                                            input logic [7:0] sm, input logic [3:0] pl,
                                            input logic [15:0] g, input logic on);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            int s;
            s = int'(sm[2*i +: 2]);
            r[i] = (on && run && (s * eff_gap(g) <= el)) ^ pl[i];
        end
        return r;
    endfunction

    function automatic logic exp_done(input logic run, input int el,
                                      input logic [15:0] g, input logic on);
        return on && run && (el >= 4 * eff_gap(g));
    endfunction

    task automatic check_now(input string tag);
        logic [3:0] ep;
        logic       ed;
        logic       on;
        on = rst_n && en;
        ep = exp_pull(m_run, m_el, smap, pol, gap, on);
        ed = exp_done(m_run, m_el, gap, on);
        checks++;
        if (pull_low !== ep || seq_done !== ed) begin
            fails++;
            $display("FAIL %s: pull_low=%b done=%b expected pull_low=%b done=%b",
                     tag, pull_low, seq_done, ep, ed);
        end
    endtask

    // mode 0: flags true from start; 1: gate pulse then late drain;
    // 2: drain never low; 3: random flags; 4: enable drop then re-enable.
    task automatic run_case(input logic [7:0] sm, input logic [3:0] pl,
                            input logic [15:0] g, input logic cr, input int mode,
                            input int ncyc, input string tag);
        @(negedge clk);
        en = 1'b0; gate_f = 1'b0; drain_l = 1'b0;
        smap = sm; pol = pl; gap = g; creg = cr;
        @(negedge clk);
        check_now(tag);
        en = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            check_now(tag);
            case (mode)
                0: begin gate_f = 1'b1; drain_l = 1'b1; end
                1: begin gate_f = (c == 2); drain_l = (c >= 6); end
                2: begin gate_f = 1'b1; drain_l = 1'b0; end
                3: begin gate_f = ($urandom_range(0, 3) == 0); drain_l = $urandom_range(0, 1) == 1; end
                default: begin
                    gate_f  = (c < 2);
                    drain_l = 1'b1;
                    en      = !(c == 6);
                end
            endcase
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check_now("R1 reset inactive");
        pol = 4'b1010;
        @(negedge clk);
        check_now("R1 reset with polarity");
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R1 disabled after reset");

        run_case(8'b11_10_01_00, 4'b0000, 16'd0, 1'b0, 0, 12, "R5 zero gap, R6 order");
        run_case(8'b00_01_10_11, 4'b0000, 16'd3, 1'b0, 0, 20, "R2 R6 R9 reverse order");
        run_case(8'b11_11_11_11, 4'b0000, 16'd3, 1'b0, 0, 20, "R7 shared slot, empty slots");
        run_case(8'b01_01_00_00, 4'b0110, 16'd2, 1'b0, 0, 14, "R8 polarity R7");
        run_case(8'b11_10_01_00, 4'b0000, 16'd2, 1'b0, 1, 20, "R3 gate pulse latched");
        run_case(8'b11_10_01_00, 4'b0000, 16'd2, 1'b0, 2, 15, "R2 drain high blocks");
        run_case(8'b11_10_01_00, 4'b1001, 16'd2, 1'b1, 2, 15, "R4 regulation masks drain");
        run_case(8'b00_01_10_11, 4'b0000, 16'd4, 1'b0, 4, 30, "R10 drop needs new gate");

        for (int n = 0; n < 24; n++) begin
            logic [7:0]  sm;
            logic [3:0]  pl;
            logic [15:0] g;
            logic        cr;
            int          md;
            sm = 8'($urandom);
            pl = 4'($urandom);
            g  = 16'($urandom_range(0, 6));
            cr = ($urandom_range(0, 3) == 0);
            md = $urandom_range(0, 4);
            run_case(sm, pl, g, cr, md, 4 * eff_gap(g) + 14, "R5 R6 R9 random");
        end

        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check_now("R10 final disable");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule